// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a 24-bit general-purpose pin vector in which 23 pins are implemented. The pins form three groups: group 0 holds pins 7..0, group 1 holds pins 14..8, and group 2 holds pins 23..16. Pin 15 does not exist. Each pin has its own select bit in a per-group mask register. When a selected pin changes level in either direction, the flag shared by its group is set.

Each group drives one interrupt request. The request is high when the group flag, the group enable and the single global enable are all set. A flag is cleared by a pulse on the group's acknowledge input, or by software writing a one to that flag bit. A flag is set even while the request for that group is gated off, so the event is kept until the group is enabled.

Software reaches the block through a simple register port: a one-cycle write strobe with an address and data, and a read address whose data appears on a registered output.

Top module: `pcint_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle that follows it, every request is low and every register reads as zero.
- R2: The register map is as follows. Address 0 bit 0 is the global enable. Address 1 bits [2:0] are the group enables. Address 2 bits [2:0] are the group flags, where writing a one clears a flag. Addresses 3, 4 and 5 are the mask registers of groups 0, 1 and 2. All unused bits, and addresses 6 and 7, read as zero. The value for rd_addr is on rd_data one clock edge after rd_addr is applied. A write takes effect on the clock edge where wr_en is high.
- R3: pin_i[7:0] belongs to group 0, pin_i[14:8] to group 1 and pin_i[23:16] to group 2. pin_i[15] never sets a flag. Mask bit 7 of group 1 always reads as zero and cannot be set.
- R4: A rising transition and a falling transition on a pin whose mask bit is one both set that pin's group flag.
- R5: A transition on a pin whose mask bit is zero leaves every flag clear.
- R6: A flag is set by a toggle even when its group enable or the global enable is zero. The request rises once both enables are set.
- R7: irq_o[g] is the registered AND of flag g, group enable g and the global enable. It lags each of these by one clock.
- R8: A high ack_i[g] clears flag g on that clock edge. If a new toggle sets the flag on the same edge, the flag stays set.
- R9: Writing to address 2 clears the flags whose data bits are one. Flags whose data bits are zero keep their value.
- R10: A pin held at a steady level does not set its flag again after the flag is cleared.
- R11: Pins pass through a two-stage synchroniser. If a pin changes before clock edge k, with both enables and the mask bit already set, the flag is set on edge k+2 and the request rises on edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 24 | Asynchronous pin levels (bit 15 unused) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| ack_i | input | 3 | Per-group acknowledge, clears the flag |
| irq_o | output | 3 | Per-group registered interrupt request |

## Verification
The assertions assume that reset is held high for at least one clock edge before any check, so the pin history registers start from a known state. They also assume that acknowledge and write strobes are synchronous one-cycle inputs. The flag-rise check assumes that a flag only becomes set in a cycle that followed a masked toggle. For that to hold, pins must be steady whenever their mask bits are written. The bench holds all pins low through reset, changes the pins only on falling clock edges, and changes them only after the masks are configured. Every strobe is driven for exactly one cycle.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  localparam int unsigned AW = 3;
  typedef logic [AW-1:0] reg_addr_t;
  localparam reg_addr_t ADDR_GIE   = 3'd0;
  localparam reg_addr_t ADDR_GEN   = 3'd1;
  localparam reg_addr_t ADDR_FLAG  = 3'd2;
  localparam reg_addr_t ADDR_MASK0 = 3'd3;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
  parameter int unsigned N = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] toggle_o
);
  logic [N-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  // Any level difference between the two newest samples is a toggle.
  assign toggle_o = sync_q ^ last_q;
endmodule

// File: rtl/pcint_group.sv
module pcint_group #(
  parameter int unsigned GW = 8,
  parameter logic [GW-1:0] IMPL = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] toggle_i,
  input  logic          mask_we,
  input  logic [GW-1:0] mask_wdata,
  input  logic          clr_i,
  input  logic          gen_i,
  input  logic          gie_i,
  output logic [GW-1:0] mask_o,
  output logic          hit_o,
  output logic          flag_o,
  output logic          irq_o
);
  logic [GW-1:0] mask_q;
  logic          flag_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata & IMPL;
  end

  assign hit_o = |(toggle_i & mask_q);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else if (hit_o) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else irq_q <= flag_q & gen_i & gie_i;
  end

  assign mask_o = mask_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/pcint_ctrl.sv
module pcint_ctrl
  import pcint_pkg::*;
#(
  parameter int unsigned NG = 3,
  parameter int unsigned GW = 8,
  parameter int unsigned RW = 8,
  parameter logic [NG*GW-1:0] IMPL_MAP = 24'hFF7FFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NG*GW-1:0]   pin_i,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [RW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [RW-1:0]      rd_data,
  input  logic [NG-1:0]      ack_i,
  output logic [NG-1:0]      irq_o
);
  localparam int unsigned NPIN = NG * GW;

  logic [NPIN-1:0] toggle;
  logic [NPIN-1:0] mask_all;
  logic [NG-1:0]   flag_vec, hit_vec, gen_q;
  logic            gie_q;
  logic [RW-1:0]   rd_q, rd_next;

  pcint_sync #(.N(NPIN)) sync_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .toggle_o(toggle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q <= 1'b0;
      gen_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_GIE) gie_q <= wr_data[0];
      if (wr_addr == ADDR_GEN) gen_q <= wr_data[NG-1:0];
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic mask_we, clr;
    assign mask_we = wr_en && (wr_addr == reg_addr_t'(ADDR_MASK0 + g));
    assign clr     = ack_i[g] || (wr_en && wr_addr == ADDR_FLAG && wr_data[g]);
    pcint_group #(.GW(GW), .IMPL(IMPL_MAP[g*GW +: GW])) grp_i (
      .clk(clk), .rst(rst),
      .toggle_i(toggle[g*GW +: GW]),
      .mask_we(mask_we), .mask_wdata(wr_data[GW-1:0]),
      .clr_i(clr), .gen_i(gen_q[g]), .gie_i(gie_q),
      .mask_o(mask_all[g*GW +: GW]),
      .hit_o(hit_vec[g]), .flag_o(flag_vec[g]), .irq_o(irq_o[g])
    );
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == ADDR_GIE)       rd_next[0] = gie_q;
    else if (rd_addr == ADDR_GEN)  rd_next[NG-1:0] = gen_q;
    else if (rd_addr == ADDR_FLAG) rd_next[NG-1:0] = flag_vec;
    else begin
      for (int g = 0; g < NG; g++)
        if (rd_addr == reg_addr_t'(ADDR_MASK0 + g))
          rd_next[GW-1:0] = mask_all[g*GW +: GW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else rd_q <= rd_next;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/pcint_ctrl_chk.sv
module pcint_ctrl_chk
  import pcint_pkg::*;
#(
  parameter int unsigned NG = 3,
  parameter int unsigned RW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] rd_addr,
  input logic [RW-1:0] rd_data,
  input logic [NG-1:0] ack_i,
  input logic [NG-1:0] irq_o,
  input logic [NG-1:0] flag_vec,
  input logic [NG-1:0] hit_vec,
  input logic [NG-1:0] gen_q,
  input logic          gie_q
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && rd_data == '0));

  // R7
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
    (irq_o & ~$past(flag_vec & gen_q & {NG{gie_q}})) == '0);

  // R4, R5
  a_r4_flag_needs_hit: assert property (@(posedge clk) disable iff (rst)
    ((flag_vec & ~$past(flag_vec)) & ~$past(hit_vec)) == '0);

  // R8
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ($past(ack_i & ~hit_vec) & flag_vec) == '0);

  // R2
  a_r2_gen_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == ADDR_GEN) |-> (rd_data[RW-1:NG] == '0));

  // R3
  a_r3_pin15_mask_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == 3'd4) |-> (rd_data[7] == 1'b0));
endmodule

bind pcint_ctrl pcint_ctrl_chk #(.NG(NG), .RW(RW)) chk_i (
  .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
  .ack_i(ack_i), .irq_o(irq_o), .flag_vec(flag_vec), .hit_vec(hit_vec),
  .gen_q(gen_q), .gie_q(gie_q)
);

// File: tb/pcint_ctrl_tb_top.sv
module pcint_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] pin_i = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [2:0]  ack_i = '0;
  logic [2:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pcint_ctrl dut_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ack_i(ack_i), .irq_o(irq_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic ack(logic [2:0] m);
    @(negedge clk);
    ack_i = m;
    @(negedge clk);
    ack_i = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq", int'(irq_o), 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reg", int'(d), 0);
    end
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(3'd0, 8'hFF); rd(3'd0, d); check("R2 gie", int'(d), 8'h01);
    wr(3'd1, 8'hFF); rd(3'd1, d); check("R2 gen upper", int'(d), 8'h07);
    wr(3'd3, 8'hA5); rd(3'd3, d); check("R2 mask0", int'(d), 8'hA5);
    wr(3'd4, 8'hFF); rd(3'd4, d); check("R3 mask1 bit7", int'(d), 8'h7F);
    wr(3'd5, 8'h3C); rd(3'd5, d); check("R2 mask2", int'(d), 8'h3C);
    wr(3'd6, 8'hFF); rd(3'd6, d); check("R2 addr6", int'(d), 0);
    wr(3'd3, 8'h01); wr(3'd4, 8'h01); wr(3'd5, 8'h01);
  endtask

  task automatic t_latency;
    @(negedge clk);
    pin_i[16] = 1'b1;
    cyc(3);
    check("R11 irq before", int'(irq_o[2]), 0);
    cyc(1);
    check("R11 irq after", int'(irq_o[2]), 1);
    ack(3'b100); cyc(1);
    check("R8 ack clears irq", int'(irq_o[2]), 0);
  endtask

  task automatic t_rise_fall;
    logic [7:0] d;
    @(negedge clk); pin_i[0] = 1'b1; cyc(4);
    rd(3'd2, d); check("R4 rise flag", int'(d), 8'h01);
    check("R4 rise irq", int'(irq_o), 3'b001);
    ack(3'b001); rd(3'd2, d); check("R8 ack", int'(d), 0);
    @(negedge clk); pin_i[0] = 1'b0; cyc(4);
    rd(3'd2, d); check("R4 fall flag", int'(d), 8'h01);
    ack(3'b001);
  endtask

  task automatic t_unmasked;
    logic [7:0] d;
    @(negedge clk); pin_i[1] = 1'b1; pin_i[15] = 1'b1; pin_i[17] = 1'b1; cyc(5);
    rd(3'd2, d); check("R5 unmasked flag", int'(d), 0);
    check("R3 pin15 irq", int'(irq_o), 0);
    @(negedge clk); pin_i[1] = 1'b0; pin_i[15] = 1'b0; pin_i[17] = 1'b0; cyc(5);
    rd(3'd2, d); check("R5 unmasked fall", int'(d), 0);
  endtask

  task automatic t_remember;
    logic [7:0] d;
    wr(3'd1, 8'h00);
    @(negedge clk); pin_i[8] = 1'b1; cyc(5);
    rd(3'd2, d); check("R6 flag while disabled", int'(d), 8'h02);
    check("R6 no irq", int'(irq_o), 0);
    wr(3'd0, 8'h00); wr(3'd1, 8'h07); cyc(1);
    check("R7 gie gates", int'(irq_o), 0);
    wr(3'd0, 8'h01);
    check("R7 irq lag", int'(irq_o), 0);
    cyc(1);
    check("R6 irq once enabled", int'(irq_o), 3'b010);
    ack(3'b010);
  endtask

  task automatic t_ack_race;
    logic [7:0] d;
    @(negedge clk); pin_i[0] = 1'b1; cyc(4);
    @(negedge clk); pin_i[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); ack_i = 3'b001;
    @(negedge clk); ack_i = '0;
    rd(3'd2, d); check("R8 set wins", int'(d), 8'h01);
    ack(3'b001);
  endtask

  task automatic t_w1c;
    logic [7:0] d;
    @(negedge clk); pin_i[0] = 1'b1; pin_i[16] = 1'b0; cyc(5);
    rd(3'd2, d); check("R9 both set", int'(d), 8'h05);
    wr(3'd2, 8'h04); rd(3'd2, d); check("R9 clear one", int'(d), 8'h01);
    wr(3'd2, 8'h01); rd(3'd2, d); check("R9 clear other", int'(d), 0);
    cyc(10);
    rd(3'd2, d); check("R10 held level", int'(d), 0);
    check("R10 irq", int'(irq_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_regs();
    t_latency();
    t_rise_fall();
    t_unmasked();
    t_remember();
    t_ack_race();
    t_w1c();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule